// File: doc/BRIEF.md
# Interrupt Pin Service Logic

This block decides, for every interrupt input pin, when an interrupt message goes out to the processors. Each pin has its own redirection entry: vector, destination, delivery mode, destination addressing mode, trigger mode and mask. Per pin the block keeps a pending-request bit. For level-triggered entries it also keeps a remote-pending flag, which records that a delivery was accepted and that its end-of-interrupt (EOI) has not yet arrived.

When at least one pin is ready, the block presents a delivery request for the lowest-numbered ready pin. The fields of that request are copied from the pin's entry. In the same cycle the delivery port answers whether at least one processor accepted it. EOI events carry a vector and a trigger mode. Every entry whose vector matches gets an ack pulse in the EOI cycle. A level-mode EOI also re-arms the matching level entries, so a line that is still asserted is serviced again in the next cycle. A write strobe tells the block that a pin's entry was rewritten. This clears that pin's remote-pending flag, so the pin is serviced again at once if its request is still pending.

Top module: `irq_pin_service`

## Requirements
- R1: After reset no request or remote-pending flag is set, and `dlv_valid` and `ack_pin` are low.
- R2: A pin sampled low at a clock edge clears its request bit. A pin that goes high while masked and then low before unmasking is never delivered.
- R3: For an edge entry (`cfg_level`=0), a rising edge of the pin sets the request. Issuing the delivery clears the request. A pin held high after that gives no further delivery until it falls and rises again.
- R4: For a level entry (`cfg_level`=1), a high pin keeps the request set. While remote-pending is set, no delivery is made for that pin.
- R5: A masked entry (`cfg_mask`=1) is never delivered. Its request stays pending, so unmasking while the pin is still high delivers it in the same cycle.
- R6: A level delivery with `dlv_accept`=1 sets remote-pending. With `dlv_accept`=0 the request is presented again in the next cycle.
- R7: An EOI with `eoi_level`=1 raises `ack_pin[i]` in its own cycle for every entry whose vector equals `eoi_vector`, and clears those entries' remote-pending flags at the clock edge. A still-high level pin is delivered again in the next cycle.
- R8: An EOI with `eoi_level`=0 raises the same ack pulses but leaves every remote-pending flag unchanged.
- R9: A `cfg_wr` pulse for pin `cfg_wr_pin` clears that pin's remote-pending flag. If its request is set, the pin is serviced in the next cycle.
- R10: When several pins are ready, only the lowest index is presented. At most one delivery is made per cycle.
- R11: `dlv_pin` gives the selected pin. `dlv_vector`, `dlv_dest`, `dlv_dmode`, `dlv_logical` and `dlv_level` equal that pin's entry fields (pin i uses bits `[i*W +: W]` of each packed field).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NPINS | Current level of each interrupt pin |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector |
| cfg_dest | input | NPINS*DEST_W | Per-pin destination |
| cfg_dmode | input | NPINS*DM_W | Per-pin delivery mode |
| cfg_logical | input | NPINS | Per-pin logical destination addressing |
| cfg_level | input | NPINS | 1 = level trigger, 0 = edge trigger |
| cfg_mask | input | NPINS | 1 = entry masked |
| cfg_wr | input | 1 | Entry of pin cfg_wr_pin was rewritten |
| cfg_wr_pin | input | PIN_W | Pin whose entry was rewritten |
| dlv_valid | output | 1 | Delivery request this cycle |
| dlv_accept | input | 1 | At least one processor accepted the request |
| dlv_pin | output | PIN_W | Pin being delivered |
| dlv_vector | output | VEC_W | Vector of the delivery |
| dlv_dest | output | DEST_W | Destination of the delivery |
| dlv_dmode | output | DM_W | Delivery mode of the delivery |
| dlv_logical | output | 1 | Logical addressing flag of the delivery |
| dlv_level | output | 1 | Trigger mode of the delivery |
| eoi_valid | input | 1 | EOI event |
| eoi_vector | input | VEC_W | Vector named by the EOI |
| eoi_level | input | 1 | EOI is for a level-triggered interrupt |
| ack_pin | output | NPINS | Ack notification per matching entry |

## Verification
A wrong request bit shows one cycle after the pin edge. It appears as a delivery that should not happen, or as a missing one on `dlv_valid`/`dlv_pin`, once the pin is unmasked. A stuck or wrongly cleared remote-pending flag shows only on a level pin that is still high. It shows as a redelivery before its EOI, or as a silent line after an EOI or an entry rewrite, in the cycle right after that event. The bench therefore keeps level lines asserted across EOIs and rewrites. It shares vectors between pins, so one EOI re-arms several entries at once and the priority order among them becomes visible.

// File: rtl/irq_pin_service_pkg.sv
package irq_pin_service_pkg;

    typedef struct packed {
        logic prev;    // pin level at the previous edge
        logic req;     // pending request
        logic remote;  // level delivery awaiting EOI
    } pin_st_t;

    localparam pin_st_t PIN_ST_RESET = '{prev: 1'b0, req: 1'b0, remote: 1'b0};

endpackage

// File: rtl/ips_pin_ctl.sv
module ips_pin_ctl
    import irq_pin_service_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_lvl,
    input  logic level,
    input  logic mask,
    input  logic sel,
    input  logic accept,
    input  logic eoi_rearm,
    input  logic wr_hit,
    output logic ready,
    output logic remote_o
);

    pin_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_lvl;
        if (!pin_lvl) begin
            st_d.req = 1'b0;
        end else if (level) begin
            st_d.req = 1'b1;
        end else begin
            st_d.req = (st_q.req & ~sel) | ~st_q.prev;
        end
        if (level && sel && accept) begin
            st_d.remote = 1'b1;
        end else if (eoi_rearm || wr_hit) begin
            st_d.remote = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PIN_ST_RESET;
        else        st_q <= st_d;
    end

    assign ready    = st_q.req & ~mask & ~(level & st_q.remote);
    assign remote_o = st_q.remote;

    // R2: a low sample leaves no request behind
    a_r2_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_lvl |=> !st_q.req);
    // R4: a level pin is never chosen while it awaits EOI
    a_r4_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && level) |-> !st_q.remote);
    // R5: the picker never grants a masked pin
    a_r5_no_masked: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> !mask);
    // R6: accepted level delivery arms remote-pending
    a_r6_accept_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && level && accept) |=> st_q.remote);
    // R7: level EOI match clears remote-pending when no new delivery competes
    a_r7_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_rearm && !sel) |=> !st_q.remote);
    // R3: edge delivery with the pin held high leaves no request
    a_r3_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !level && pin_lvl && st_q.prev) |=> !st_q.req);

endmodule

// File: rtl/ips_prio_pick.sv
module ips_prio_pick #(
    parameter int N     = 8,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service #(
    parameter int NPINS  = 8,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    parameter int DM_W   = 3,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        pin_lvl,
    input  logic [NPINS*VEC_W-1:0]  cfg_vector,
    input  logic [NPINS*DEST_W-1:0] cfg_dest,
    input  logic [NPINS*DM_W-1:0]   cfg_dmode,
    input  logic [NPINS-1:0]        cfg_logical,
    input  logic [NPINS-1:0]        cfg_level,
    input  logic [NPINS-1:0]        cfg_mask,
    input  logic                    cfg_wr,
    input  logic [PIN_W-1:0]        cfg_wr_pin,
    output logic                    dlv_valid,
    input  logic                    dlv_accept,
    output logic [PIN_W-1:0]        dlv_pin,
    output logic [VEC_W-1:0]        dlv_vector,
    output logic [DEST_W-1:0]       dlv_dest,
    output logic [DM_W-1:0]         dlv_dmode,
    output logic                    dlv_logical,
    output logic                    dlv_level,
    input  logic                    eoi_valid,
    input  logic [VEC_W-1:0]        eoi_vector,
    input  logic                    eoi_level,
    output logic [NPINS-1:0]        ack_pin
);

    logic [NPINS-1:0] ready, grant, remote;

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic vec_hit;
        assign vec_hit    = eoi_valid && (cfg_vector[g*VEC_W +: VEC_W] == eoi_vector);
        assign ack_pin[g] = vec_hit;

        ips_pin_ctl u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_lvl  (pin_lvl[g]),
            .level    (cfg_level[g]),
            .mask     (cfg_mask[g]),
            .sel      (grant[g]),
            .accept   (dlv_accept),
            .eoi_rearm(vec_hit && eoi_level),
            .wr_hit   (cfg_wr && (cfg_wr_pin == PIN_W'(g))),
            .ready    (ready[g]),
            .remote_o (remote[g])
        );
    end

    ips_prio_pick #(.N(NPINS)) u_pick (
        .req  (ready),
        .grant(grant),
        .any  (dlv_valid),
        .idx  (dlv_pin)
    );

    assign dlv_vector  = cfg_vector[dlv_pin*VEC_W +: VEC_W];
    assign dlv_dest    = cfg_dest[dlv_pin*DEST_W +: DEST_W];
    assign dlv_dmode   = cfg_dmode[dlv_pin*DM_W +: DM_W];
    assign dlv_logical = cfg_logical[dlv_pin];
    assign dlv_level   = cfg_level[dlv_pin];

    // R10: at most one pin granted per cycle
    a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R10: no ready pin below the delivered one
    a_r10_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ((ready & ((NPINS'(1) << dlv_pin) - NPINS'(1))) == '0));
    // R8: edge EOI leaves remote flags alone when nothing else touches them
    a_r8_edge_eoi_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !eoi_level && !cfg_wr && !dlv_valid) |=> $stable(remote));
    // R1: nothing is pending right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (remote == '0 && !dlv_valid));

endmodule

// File: tb/irq_pin_service_tb.sv
module irq_pin_service_tb;

    localparam int N = 8, VW = 8, DW = 8, MW = 3, PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    pin_lvl = '0, cfg_logical, cfg_level = '0, cfg_mask = '0;
    logic [N*VW-1:0] cfg_vector;
    logic [N*DW-1:0] cfg_dest;
    logic [N*MW-1:0] cfg_dmode;
    logic            cfg_wr = 1'b0, dlv_accept = 1'b0, eoi_valid = 1'b0, eoi_level = 1'b0;
    logic [PW-1:0]   cfg_wr_pin = '0;
    logic [VW-1:0]   eoi_vector = '0;
    logic            dlv_valid, dlv_logical, dlv_level;
    logic [PW-1:0]   dlv_pin;
    logic [VW-1:0]   dlv_vector;
    logic [DW-1:0]   dlv_dest;
    logic [MW-1:0]   dlv_dmode;
    logic [N-1:0]    ack_pin;

    int checks = 0, errors = 0;
    logic [N-1:0] m_prev = '0, m_req = '0, m_rem = '0;
    logic [N-1:0] n_prev, n_req, n_rem;

    always #2.5 clk = ~clk;

    irq_pin_service #(.NPINS(N), .VEC_W(VW), .DEST_W(DW), .DM_W(MW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cfg_vector(cfg_vector),
        .cfg_dest(cfg_dest), .cfg_dmode(cfg_dmode), .cfg_logical(cfg_logical),
        .cfg_level(cfg_level), .cfg_mask(cfg_mask), .cfg_wr(cfg_wr),
        .cfg_wr_pin(cfg_wr_pin), .dlv_valid(dlv_valid), .dlv_accept(dlv_accept),
        .dlv_pin(dlv_pin), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
        .dlv_dmode(dlv_dmode), .dlv_logical(dlv_logical), .dlv_level(dlv_level),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
        .ack_pin(ack_pin)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] vec_of(input int i);
        return cfg_vector[i*VW +: VW];
    endfunction

    // Called at a negative edge with inputs applied; checks, then advances the model.
    task automatic tick(input string tag);
        logic [N-1:0] rdy, hit;
        logic ev;
        int ep;
        #1;
        rdy = m_req & ~cfg_mask & ~(cfg_level & m_rem);
        ev = |rdy;
        ep = 0;
        for (int i = N - 1; i >= 0; i--) if (rdy[i]) ep = i;
        for (int i = 0; i < N; i++) hit[i] = eoi_valid && (vec_of(i) == eoi_vector);
        chk(tag, "dlv_valid", 32'(dlv_valid), 32'(ev));
        chk(tag, "ack_pin", 32'(ack_pin), 32'(hit));
        if (ev) begin
            chk(tag, "dlv_pin R10", 32'(dlv_pin), 32'(ep));
            chk(tag, "fields R11", {dlv_vector, dlv_dest, 5'(dlv_dmode), dlv_logical, dlv_level, 9'd0},
                {vec_of(ep), cfg_dest[ep*DW +: DW], 5'(cfg_dmode[ep*MW +: MW]),
                 cfg_logical[ep], cfg_level[ep], 9'd0});
        end
        for (int i = 0; i < N; i++) begin
            logic s;
            s = ev && (ep == i);
            n_prev[i] = pin_lvl[i];
            if (!pin_lvl[i])       n_req[i] = 1'b0;
            else if (cfg_level[i]) n_req[i] = 1'b1;
            else                   n_req[i] = (m_req[i] & ~s) | ~m_prev[i];
            if (cfg_level[i] && s && dlv_accept) n_rem[i] = 1'b1;
            else if ((hit[i] && eoi_level) || (cfg_wr && cfg_wr_pin == PW'(i))) n_rem[i] = 1'b0;
            else n_rem[i] = m_rem[i];
        end
        @(posedge clk);
        m_prev = n_prev; m_req = n_req; m_rem = n_rem;
        @(negedge clk);
        cfg_wr = 1'b0; eoi_valid = 1'b0;
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            cfg_vector[i*VW +: VW] = VW'(8'h40 + (i % 3));
            cfg_dest[i*DW +: DW]   = DW'(i * 17 + 3);
            cfg_dmode[i*MW +: MW]  = MW'(i);
            cfg_logical[i]         = i[0];
        end
        cfg_level = 8'b0001_0110;   // pins 1, 2, 4 level; 1 and 4 share vector 0x41
        repeat (3) @(negedge clk);
        chk("R1", "dlv_valid in reset", 32'(dlv_valid), 0);
        chk("R1", "ack in reset", 32'(ack_pin), 0);
        rst_n = 1'b1;
        tick("R1");

        // R2: masked pulse then low, unmask: nothing delivered
        cfg_mask[0] = 1'b1; pin_lvl[0] = 1'b1; tick("R2");
        tick("R2");
        pin_lvl[0] = 1'b0; tick("R2");
        cfg_mask[0] = 1'b0; tick("R2"); tick("R2");

        // R3: edge delivered once, held high gives nothing more
        pin_lvl[0] = 1'b1; tick("R3");
        tick("R3"); tick("R3"); tick("R3");
        pin_lvl[0] = 1'b0; tick("R3");

        // R5: masked edge pending, unmask while high delivers
        cfg_mask[3] = 1'b1; pin_lvl[3] = 1'b1; tick("R5"); tick("R5"); tick("R5");
        cfg_mask[3] = 1'b0; tick("R5"); tick("R5");

        // R6: level pin not accepted redelivers, then accepted holds off (R4)
        dlv_accept = 1'b0; pin_lvl[1] = 1'b1; tick("R6"); tick("R6"); tick("R6");
        dlv_accept = 1'b1; tick("R6"); tick("R4"); tick("R4");

        // R10: level pin 4 also raised, same vector as pin 1
        pin_lvl[4] = 1'b1; tick("R10"); tick("R4");

        // R8: edge-mode EOI acks but keeps remote flags
        eoi_valid = 1'b1; eoi_vector = 8'h41; eoi_level = 1'b0; tick("R8");
        tick("R8"); tick("R8");

        // R7: level EOI re-arms pins 1 and 4; both redelivered, lowest first
        eoi_valid = 1'b1; eoi_vector = 8'h41; eoi_level = 1'b1; tick("R7");
        tick("R7"); tick("R7"); tick("R7");

        // R9: rewrite pin 4 re-services it
        cfg_wr = 1'b1; cfg_wr_pin = 3'd4; tick("R9"); tick("R9"); tick("R9");

        // R2: level pin drops, cleared even with remote-pending
        pin_lvl[1] = 1'b0; tick("R2");
        cfg_wr = 1'b1; cfg_wr_pin = 3'd1; tick("R2"); tick("R2");

        // Random mix
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 3) == 0) pin_lvl[$urandom_range(0, N-1)] ^= 1'b1;
            if ($urandom_range(0, 15) == 0) cfg_mask[$urandom_range(0, N-1)] ^= 1'b1;
            if ($urandom_range(0, 63) == 0) cfg_level[$urandom_range(0, N-1)] ^= 1'b1;
            dlv_accept = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 5) == 0) begin
                eoi_valid = 1'b1; eoi_vector = VW'(8'h40 + $urandom_range(0, 3));
                eoi_level = ($urandom_range(0, 3) != 0);
            end
            if ($urandom_range(0, 19) == 0) begin
                cfg_wr = 1'b1; cfg_wr_pin = PW'($urandom_range(0, N-1));
            end
            tick("R10");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule